// File: doc/BRIEF.md
# E1 Resync Criterion Monitor

This block sits beside the receive framer of an E1 line and decides when each framing level has lost alignment badly enough that a fresh search is due. The framer hands it a single-cycle strobe each time it has examined one of three things: a frame alignment word, a CAS multiframe alignment word, or a CRC4 codeword comparison. Each strobe comes with a result bit, high when that check failed. The block only counts these results and applies one criterion per level. It does not detect alignment words, compute CRC4 or run the search.

The frame alignment and CAS levels use runs of consecutive failures. Each is handled by a two-state machine. `RUN_CLEAN` moves to `RUN_ERRING` on a failed check. `RUN_ERRING` returns to `RUN_CLEAN` in two cases: when a check passes, or when the run reaches its limit, at which point it fires and restarts. The CRC4 level counts failures inside fixed, non-overlapping blocks of 1000 checks. `WIN_WATCH` moves to `WIN_FIRED` when the failure count reaches 915. Both states return to `WIN_WATCH` on the last check of a block, and the counts restart there.

Each criterion sets a sticky flag in an 8-bit status word. A host clears a flag by writing a one to it.

Top module: `e1_resync_monitor`

## Requirements
- R1: Three failed frame alignment checks in a row set status bit 1 at the clock edge that samples the third one. Two in a row do not set it.
- R2: Two failed CAS multiframe alignment checks in a row set status bit 0 at the clock edge that samples the second one.
- R3: A strobe whose result bit is low counts as a passed check and returns that level's run to zero. A result bit without its strobe is ignored.
- R4: When a run criterion fires, that run restarts from zero, so the full number of further consecutive failures is needed before it fires again.
- R5: Status bit 2 is set at the edge that samples the 915th failed CRC4 check within the current block of 1000 checks. A block that holds only 914 failures leaves the bit clear.
- R6: CRC4 blocks do not overlap. Both the check count and the failure count restart after every 1000th check, so failures from two neighbouring blocks never add together.
- R7: Status bits are sticky. When `clr_we` is high, each bit whose `clr_mask` position is one is cleared, and bits whose mask position is zero are left untouched. `clr_mask` bits 0, 1 and 2 map to status bits 0, 1 and 2.
- R8: If a criterion fires in the same cycle as a clear of its bit, the bit stays set.
- R9: A synchronous active-high reset clears all run counts, block counts and status bits.
- R10: Status bits 7 down to 3 always read zero, even when all three flags are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fas_stb | input | 1 | A frame alignment word was checked this cycle |
| fas_err | input | 1 | That frame alignment word was wrong |
| mf_stb | input | 1 | A CAS multiframe alignment word was checked this cycle |
| mf_err | input | 1 | That multiframe word was wrong |
| crc_stb | input | 1 | A CRC4 codeword comparison finished this cycle |
| crc_err | input | 1 | That comparison mismatched |
| clr_we | input | 1 | Host clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask for status bits 2..0 |
| status | output | 8 | Bit 0 CAS event, bit 1 FAS event, bit 2 CRC event, bits 7..3 zero |

## Verification
The assertions assume that each strobe is a single-cycle pulse per check, and that a result bit matters only while its strobe is high. They make no assumption about how often strobes arrive or about the spacing between them. The stimulus drives every strobe for exactly one clock and then drops it. It also deliberately raises result bits without their strobe, to confirm that they are ignored. CRC4 checks are sent back to back, and the bench counts them itself so that every block boundary falls exactly on a multiple of 1000.

// File: rtl/e1rm_pkg.sv
`timescale 1ns/1ps
package e1rm_pkg;
    localparam int EVT_N   = 3;
    localparam int STAT_W  = 8;
    localparam int BIT_CAS = 0;
    localparam int BIT_FAS = 1;
    localparam int BIT_CRC = 2;

    typedef enum logic {
        RUN_CLEAN,
        RUN_ERRING
    } run_state_t;

    typedef enum logic {
        WIN_WATCH,
        WIN_FIRED
    } win_state_t;
endpackage

// File: rtl/e1rm_run_monitor.sv
`timescale 1ns/1ps
module e1rm_run_monitor
    import e1rm_pkg::*;
#(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic err,
    output logic hit
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    run_state_t     state, state_n;
    logic [CW-1:0]  cnt, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RUN_CLEAN;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            RUN_CLEAN: begin
                if (stb && err) begin
                    state_n = RUN_ERRING;
                    cnt_n   = ONE;
                end
            end
            RUN_ERRING: begin
                if (stb) begin
                    if (!err) begin
                        state_n = RUN_CLEAN;
                        cnt_n   = '0;
                    end else if (cnt == LAST) begin
                        state_n = RUN_CLEAN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n   = cnt + ONE;
                    end
                end
            end
            default: begin
                state_n = RUN_CLEAN;
                cnt_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        hit = 1'b0;
        unique case (state)
            RUN_CLEAN:  hit = 1'b0;
            RUN_ERRING: hit = stb && err && (cnt == LAST);
            default:    hit = 1'b0;
        endcase
    end

    // R3: a passed check empties the run
    a_r3_pass_clears: assert property (@(posedge clk) disable iff (rst)
        (stb && !err) |=> (cnt == '0));
    // R3: no strobe, no change
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(cnt));
    // R4: the run never reaches its limit as a stored count
    a_r4_count_below_limit: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(LIMIT));
    // R4: firing restarts the run
    a_r4_fire_restarts: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cnt == '0));
endmodule

// File: rtl/e1rm_crc_window.sv
`timescale 1ns/1ps
module e1rm_crc_window
    import e1rm_pkg::*;
#(
    parameter int WIN    = 1000,
    parameter int THRESH = 915
) (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic err,
    output logic hit
);
    localparam int WCW = $clog2(WIN + 1);
    localparam int ECW = $clog2(THRESH + 1);
    localparam logic [WCW-1:0] W_LAST = WCW'(WIN - 1);
    localparam logic [ECW-1:0] E_LAST = ECW'(THRESH - 1);

    win_state_t      state, state_n;
    logic [WCW-1:0]  wcnt, wcnt_n;
    logic [ECW-1:0]  ecnt, ecnt_n;
    logic            block_end;

    assign block_end = stb && (wcnt == W_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WIN_WATCH;
            wcnt  <= '0;
            ecnt  <= '0;
        end else begin
            state <= state_n;
            wcnt  <= wcnt_n;
            ecnt  <= ecnt_n;
        end
    end

    always_comb begin
        state_n = state;
        wcnt_n  = wcnt;
        ecnt_n  = ecnt;
        if (stb) begin
            if (block_end) begin
                state_n = WIN_WATCH;
                wcnt_n  = '0;
                ecnt_n  = '0;
            end else begin
                wcnt_n = wcnt + WCW'(1);
                unique case (state)
                    WIN_WATCH: begin
                        if (err) begin
                            ecnt_n = ecnt + ECW'(1);
                            if (ecnt == E_LAST) state_n = WIN_FIRED;
                        end
                    end
                    WIN_FIRED: state_n = WIN_FIRED;
                    default:   state_n = WIN_WATCH;
                endcase
            end
        end
    end

    always_comb begin
        hit = 1'b0;
        unique case (state)
            WIN_WATCH: hit = stb && err && (ecnt == E_LAST);
            WIN_FIRED: hit = 1'b0;
            default:   hit = 1'b0;
        endcase
    end

    // R6: block position stays inside the block
    a_r6_window_bound: assert property (@(posedge clk) disable iff (rst)
        wcnt < WCW'(WIN));
    // R6: the last check of a block restarts both counts
    a_r6_block_restart: assert property (@(posedge clk) disable iff (rst)
        block_end |=> (wcnt == '0) && (ecnt == '0));
    // R5: failures never outnumber checks in the block
    a_r5_err_le_checks: assert property (@(posedge clk) disable iff (rst)
        {{(WCW > ECW ? 0 : ECW-WCW+1){1'b0}}, wcnt} >= {{(ECW > WCW ? 0 : WCW-ECW+1){1'b0}}, ecnt});
    // R5: at most one firing per block
    a_r5_fire_once: assert property (@(posedge clk) disable iff (rst)
        (state == WIN_FIRED) |-> !hit);
endmodule

// File: rtl/e1rm_event_bank.sv
`timescale 1ns/1ps
module e1rm_event_bank
    import e1rm_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                         q[i] <= 1'b0;
            else if (set[i])                 q[i] <= 1'b1;
            else if (clr_we && clr_mask[i])  q[i] <= 1'b0;
        end

        // R8: a firing always leaves the bit set
        a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i]);
        // R7: a set bit stays set unless its mask bit is written
        a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
            (q[i] && !(clr_we && clr_mask[i])) |=> q[i]);
        // R7: a bit rises only on a firing
        a_r7_rise_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(q[i]) |-> $past(set[i]));
    end
endmodule

// File: rtl/e1_resync_monitor.sv
`timescale 1ns/1ps
module e1_resync_monitor
    import e1rm_pkg::*;
#(
    parameter int FAS_RUN    = 3,
    parameter int CAS_RUN    = 2,
    parameter int CRC_WIN    = 1000,
    parameter int CRC_THRESH = 915
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fas_stb,
    input  logic             fas_err,
    input  logic             mf_stb,
    input  logic             mf_err,
    input  logic             crc_stb,
    input  logic             crc_err,
    input  logic             clr_we,
    input  logic [EVT_N-1:0] clr_mask,
    output logic [STAT_W-1:0] status
);
    logic [EVT_N-1:0] fire;
    logic [EVT_N-1:0] flags;

    e1rm_run_monitor #(.LIMIT(CAS_RUN)) u_cas_run (
        .clk(clk), .rst(rst), .stb(mf_stb), .err(mf_err), .hit(fire[BIT_CAS])
    );

    e1rm_run_monitor #(.LIMIT(FAS_RUN)) u_fas_run (
        .clk(clk), .rst(rst), .stb(fas_stb), .err(fas_err), .hit(fire[BIT_FAS])
    );

    e1rm_crc_window #(.WIN(CRC_WIN), .THRESH(CRC_THRESH)) u_crc_win (
        .clk(clk), .rst(rst), .stb(crc_stb), .err(crc_err), .hit(fire[BIT_CRC])
    );

    e1rm_event_bank #(.N(EVT_N)) u_bank (
        .clk(clk), .rst(rst), .set(fire), .clr_we(clr_we),
        .clr_mask(clr_mask), .q(flags)
    );

    assign status = {{(STAT_W-EVT_N){1'b0}}, flags};

    // R9: reset empties the status word
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (status == '0));
    // R1: frame alignment flag rises only from a failed strobed check
    a_r1_fas_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(status[BIT_FAS]) |-> $past(fas_stb && fas_err));
    // R2: multiframe flag rises only from a failed strobed check
    a_r2_cas_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(status[BIT_CAS]) |-> $past(mf_stb && mf_err));
    // R5: CRC flag rises only from a failed strobed comparison
    a_r5_crc_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(status[BIT_CRC]) |-> $past(crc_stb && crc_err));
endmodule

// File: tb/test_e1_resync_monitor.sv
`timescale 1ns/1ps
module test_e1_resync_monitor;
    logic       clk = 1'b0;
    logic       rst;
    logic       fas_stb, fas_err, mf_stb, mf_err, crc_stb, crc_err;
    logic       clr_we;
    logic [2:0] clr_mask;
    logic [7:0] status;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    e1_resync_monitor i_e1_resync_monitor (
        .clk(clk), .rst(rst),
        .fas_stb(fas_stb), .fas_err(fas_err),
        .mf_stb(mf_stb), .mf_err(mf_err),
        .crc_stb(crc_stb), .crc_err(crc_err),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .status(status)
    );

    // {fs,fe,ms,me,cs,ce} {we} {mask[2:0]} {expected crc,fas,cas}
    localparam int NV = 20;
    localparam logic [12:0] VEC [NV] = '{
        13'b110000_0_000_000, // R1 fail 1
        13'b110000_0_000_000, // R1 fail 2
        13'b100000_0_000_000, // R3 pass resets run
        13'b110000_0_000_000,
        13'b110000_0_000_000, // R1 two in a row: clear
        13'b110000_0_000_010, // R1 third: set
        13'b000000_0_000_010, // R7 sticky
        13'b001100_0_000_010,
        13'b001100_0_000_011, // R2 second: set
        13'b000000_1_010_001, // R7 clear FAS only
        13'b000000_1_001_000, // R7 clear CAS
        13'b001100_0_000_000,
        13'b001100_1_001_001, // R8 set beats clear
        13'b000100_0_000_001, // R3 err without strobe
        13'b000000_1_111_000, // R7 clear all
        13'b001100_0_000_000, // R4 run restarted after firing
        13'b000100_0_000_000, // R3 ignored, run unbroken
        13'b001100_0_000_001, // R2 R4 second consecutive
        13'b000000_1_100_001, // R7 mask of other bit
        13'b000000_1_001_000
    };

    task automatic idle_inputs();
        {fas_stb, fas_err, mf_stb, mf_err, crc_stb, crc_err} = '0;
        clr_we   = 1'b0;
        clr_mask = '0;
    endtask

    // entered at a falling edge, leaves at the next falling edge
    task automatic pulse(input logic [5:0] s, input logic we, input logic [2:0] m);
        {fas_stb, fas_err, mf_stb, mf_err, crc_stb, crc_err} = s;
        clr_we   = we;
        clr_mask = m;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic check(input string req, input logic [7:0] exp);
        total++;
        if (status !== exp) begin
            bad++;
            $display("FAIL %s: status=%h expected=%h", req, status, exp);
        end
    endtask

    task automatic crc_checks(input int n, input logic e);
        for (int k = 0; k < n; k++) pulse({4'b0000, 1'b1, e}, 1'b0, 3'b000);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 reset state", 8'h00);

        // vector table: R1 R2 R3 R4 R7 R8
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][12:7], VEC[i][6], VEC[i][5:3]);
            check($sformatf("R1/R2/R3/R4/R7/R8 vector %0d", i), {5'b0, VEC[i][2:0]});
        end

        // R9: reset mid-run drops the partial run
        pulse(6'b110000, 1'b0, 3'b000);
        pulse(6'b110000, 1'b0, 3'b000);
        do_reset();
        pulse(6'b110000, 1'b0, 3'b000);
        pulse(6'b110000, 1'b0, 3'b000);
        check("R9 run cleared by reset", 8'h00);
        pulse(6'b110000, 1'b0, 3'b000);
        check("R9 R1 full run after reset", 8'h02);
        pulse(6'b000000, 1'b1, 3'b010);
        // R9: reset clears a set flag
        pulse(6'b001100, 1'b0, 3'b000);
        pulse(6'b001100, 1'b0, 3'b000);
        check("R2 before reset", 8'h01);
        do_reset();
        check("R9 flag cleared by reset", 8'h00);

        // R5: block with 914 failures does not fire
        crc_checks(914, 1'b1);
        crc_checks(86, 1'b0);
        check("R5 914 of 1000", 8'h00);
        // R5: 915th failure fires
        crc_checks(914, 1'b1);
        check("R5 at 914", 8'h00);
        crc_checks(1, 1'b1);
        check("R5 at 915", 8'h04);
        crc_checks(85, 1'b0);

        // R10: all flags set, upper bits zero
        pulse(6'b110000, 1'b0, 3'b000);
        pulse(6'b111100, 1'b0, 3'b000);
        pulse(6'b111100, 1'b0, 3'b000);
        check("R10 all flags", 8'h07);
        pulse(6'b000000, 1'b1, 3'b111);
        check("R7 clear all", 8'h00);

        // R6: 500 failures at end of one block + 500 at start of next
        crc_checks(500, 1'b0);
        crc_checks(500, 1'b1);
        crc_checks(500, 1'b1);
        crc_checks(500, 1'b0);
        check("R6 no overlap across blocks", 8'h00);
        // R6: block alignment kept: 915 failures from a fresh block fire
        crc_checks(915, 1'b1);
        check("R6 fresh block aligned", 8'h04);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule